// File: doc/BRIEF.md
# DMA Clock-Domain Alignment Unit

This block decides when the processor stalls and when it resumes around a block-transfer DMA. The DMA engine steps on one eighth of the master clock, so its work falls into 8-clock slots set by a free-running divider. When a start request arrives while the block is idle, the block halts the processor at once. It then passes through three phases: a wait for the next slot boundary, one setup slot followed by one slot per transfer, and a final pad that puts the processor back on its own cycle grid.

The entry wait is never zero. When the divider is already on a boundary, the wait is a full slot. The exit pad is never zero either. The pad is sized so that the whole stall, counted from the first halted clock, is an exact multiple of the processor cycle length latched at the request. The transfer engine itself is not part of this block. It receives one pulse at the start of each transfer slot, and one done pulse when the processor is released.

Top module: `dma_align_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the divider to phase 0 and drives `halt`, `dma_active`, `xfer_slot` and `done` low. After release, the divider advances by one every clock and wraps modulo 8.
- R2: When the block is idle and `start_req` is high at a clock edge, `halt` is high from the next clock. It stays high without a gap until the last pad clock.
- R3: The entry wait is N halted clocks with `dma_active` low, where N is between 1 and 8. `dma_active` first rises on a clock whose divider phase is 0. If the first halted clock already has phase 0, N is 8.
- R4: `dma_active` stays high for 8 + 8*C clocks: one setup slot, then C transfer slots.
- R5: `xfer_slot` pulses for one clock at the first clock of each transfer slot, which gives exactly C pulses per DMA. It never pulses during setup or outside `dma_active`.
- R6: A `xfer_count` of zero means C = 2^CNT_W transfers. Any other value means C = `xfer_count`.
- R7: `cyc_sel` is latched at the request and picks the cycle length L: 2'b00 gives 6, 2'b01 gives 8, and 2'b10 or 2'b11 give 12. The total halt length T = N + 8 + 8*C + P is a multiple of L, with the pad P between 1 and L. Later changes to `cyc_sel` have no effect on the running DMA.
- R8: `done` is high for exactly one clock: the first clock after `halt` falls.
- R9: `start_req`, `xfer_count` and `cyc_sel` are ignored while `halt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | DMA start request, sampled while idle |
| xfer_count | input | CNT_W | Number of transfers; zero means 2^CNT_W |
| cyc_sel | input | 2 | Processor cycle length select (6/8/12) |
| halt | output | 1 | Processor stall |
| dma_active | output | 1 | Setup plus transfer window |
| xfer_slot | output | 1 | Pulse at the start of each transfer slot |
| done | output | 1 | One-clock pulse after release |

## Verification
The bench builds the unit with CNT_W = 4. This keeps the zero-count case (16 transfers) within a short run, so the wrap of the remaining-transfer counter can be exercised next to ordinary counts. Idle gaps of different lengths between requests land the request on many divider phases, including the phase that forces the full 8-clock entry wait. All three cycle lengths are covered, including the reserved code, and together these reach pad lengths from 1 up to L. Requests made while busy, and `cyc_sel` changes made while busy, check that the latched values hold.

// File: rtl/dma_align_pkg.sv
package dma_align_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALIGN,
    PH_SETUP,
    PH_XFER,
    PH_RESYNC
  } phase_e;

  // Processor cycle length in master clocks for a select code.
  function automatic logic [3:0] cyc_len(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd6;
      2'b01:   return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

  // Advance a position on the processor cycle grid, wrapping at len.
  function automatic logic [3:0] grid_step(input logic [3:0] pos, input logic [3:0] len);
    return (pos == len - 4'd1) ? 4'd0 : pos + 4'd1;
  endfunction

endpackage

// File: rtl/dma_align_divider.sv
module dma_align_divider #(
  parameter int DIV_W = 3
) (
  input  logic clk,
  input  logic rst,
  output logic slot_begin,
  output logic slot_end
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign slot_begin = (div_q == '0);
  assign slot_end   = &div_q;
endmodule

// File: rtl/dma_align_grid.sv
module dma_align_grid
  import dma_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       run,
  input  logic [1:0] cyc_sel,
  output logic       grid_last
);
  logic [3:0] len_q;
  logic [3:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= 4'd6;
      pos_q <= 4'd0;
    end else if (accept) begin
      len_q <= cyc_len(cyc_sel);
      pos_q <= 4'd0;
    end else if (run) begin
      pos_q <= grid_step(pos_q, len_q);
    end
  end

  assign grid_last = (pos_q == len_q - 4'd1);
endmodule

// File: rtl/dma_align_seq.sv
module dma_align_seq
  import dma_align_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             slot_begin,
  input  logic             slot_end,
  input  logic             grid_last,
  output logic             accept,
  output logic             halt,
  output logic             dma_active,
  output logic             xfer_slot,
  output logic             done
);
  localparam int REM_W = CNT_W + 1;

  phase_e           phase_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_load;
  logic             done_q;

  assign rem_load = (xfer_count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, xfer_count};
  assign accept   = (phase_q == PH_IDLE) && start_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_req) begin
          phase_q <= PH_ALIGN;
          rem_q   <= rem_load;
        end
        PH_ALIGN: if (slot_end) phase_q <= PH_SETUP;
        PH_SETUP: if (slot_end) phase_q <= PH_XFER;
        PH_XFER: if (slot_end) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == {{(REM_W-1){1'b0}}, 1'b1}) phase_q <= PH_RESYNC;
        end
        PH_RESYNC: if (grid_last) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign halt       = (phase_q != PH_IDLE);
  assign dma_active = (phase_q == PH_SETUP) || (phase_q == PH_XFER);
  assign xfer_slot  = (phase_q == PH_XFER) && slot_begin;
  assign done       = done_q;
endmodule

// File: rtl/dma_align_unit.sv
module dma_align_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic [1:0]       cyc_sel,
  output logic             halt,
  output logic             dma_active,
  output logic             xfer_slot,
  output logic             done
);
  localparam int DIV_W = 3;

  logic slot_begin;
  logic slot_end;
  logic grid_last;
  logic accept;

  dma_align_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .slot_begin(slot_begin), .slot_end(slot_end)
  );

  dma_align_grid u_grid (
    .clk(clk), .rst(rst), .accept(accept), .run(halt),
    .cyc_sel(cyc_sel), .grid_last(grid_last)
  );

  dma_align_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .xfer_count(xfer_count),
    .slot_begin(slot_begin), .slot_end(slot_end), .grid_last(grid_last),
    .accept(accept), .halt(halt), .dma_active(dma_active),
    .xfer_slot(xfer_slot), .done(done)
  );
endmodule

// File: rtl/dma_align_chk.sv
module dma_align_chk (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic halt,
  input logic dma_active,
  input logic xfer_slot,
  input logic done,
  input logic slot_begin,
  input logic grid_last
);
  a_r2_halt_follows_request: assert property (@(posedge clk) disable iff (rst)
    (!halt && start_req) |=> halt);

  a_r3_active_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_active) |-> slot_begin);

  a_r4_active_within_halt: assert property (@(posedge clk) disable iff (rst)
    dma_active |-> halt);

  a_r5_slot_within_active: assert property (@(posedge clk) disable iff (rst)
    xfer_slot |-> (dma_active && slot_begin));

  a_r7_release_on_grid: assert property (@(posedge clk) disable iff (rst)
    $fell(halt) |-> $past(grid_last));

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (!halt && $past(halt)));
endmodule

bind dma_align_unit dma_align_chk u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .halt(halt),
  .dma_active(dma_active), .xfer_slot(xfer_slot), .done(done),
  .slot_begin(slot_begin), .grid_last(grid_last)
);

// File: tb/dma_align_unit_tb.sv
module dma_align_unit_tb;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_req = 1'b0;
  logic [CNT_W-1:0] xfer_count = '0;
  logic [1:0]       cyc_sel = 2'b00;
  logic             halt, dma_active, xfer_slot, done;

  always #2.5 clk = ~clk;

  dma_align_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .xfer_count(xfer_count),
    .cyc_sel(cyc_sel), .halt(halt), .dma_active(dma_active),
    .xfer_slot(xfer_slot), .done(done)
  );

  typedef struct { int cnt; int code; } job_t;
  job_t jobs[$];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Phase model from R1: zero in reset, +1 per clock afterwards.
  int phase_m = 0;
  always @(posedge clk) phase_m <= rst ? 0 : phase_m + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input int code);
    if (code == 0) return 6;
    if (code == 1) return 8;
    return 12;
  endfunction

  // Monitor / scoreboard
  bit prev_halt = 0, prev_done = 0, prev_active = 0;
  int hcnt, acnt, scnt, exp_n, exp_t, exp_c;
  always @(negedge clk) begin
    if (!rst) begin
      if (halt && !prev_halt) begin
        job_t j;
        int v, base, l;
        check(jobs.size() > 0, "R2 request queued", jobs.size(), 1);
        if (jobs.size() > 0) j = jobs.pop_front(); else j = '{1, 0};
        v = phase_m % 8;
        exp_n = (v == 0) ? 8 : 8 - v;
        exp_c = (j.cnt == 0) ? (1 << CNT_W) : j.cnt; // R6
        l = len_of(j.code);
        base = exp_n + 8 + 8 * exp_c;
        exp_t = base + (l - (base % l));             // R7
        hcnt = 0; acnt = 0; scnt = 0;
      end
      if (halt) begin
        if (dma_active && !prev_active)
          check(hcnt == exp_n, "R3 entry wait", hcnt, exp_n);
        hcnt++;
        if (dma_active) acnt++;
        if (xfer_slot) scnt++;
        check(!done, "R8 done low while halted", done, 0);
      end
      if (!halt && prev_halt) begin
        check(hcnt == exp_t, "R7 halt length", hcnt, exp_t);
        check(acnt == 8 + 8 * exp_c, "R4 active length", acnt, 8 + 8 * exp_c);
        check(scnt == exp_c, "R5/R6 slot pulses", scnt, exp_c);
        check(done, "R8 done after release", done, 1);
      end
      if (prev_done && !halt)
        check(!done, "R8 done single clock", done, 0);
      prev_halt = halt; prev_done = done; prev_active = dma_active;
    end
  end

  task automatic run(input int c, input int code, input int gap, input bit poke);
    @(negedge clk);
    start_req = 1'b1; xfer_count = c[CNT_W-1:0]; cyc_sel = code[1:0];
    jobs.push_back('{c, code});
    @(negedge clk);
    start_req = 1'b0;
    if (poke) begin
      // R9: request and select changes while busy are ignored
      repeat (4) @(negedge clk);
      start_req = 1'b1; xfer_count = 4'd9; cyc_sel = ~code[1:0];
      @(negedge clk);
      start_req = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!halt, "R1 halt reset", halt, 0);
    check(!dma_active, "R1 active reset", dma_active, 0);
    check(!xfer_slot, "R1 slot reset", xfer_slot, 0);
    check(!done, "R1 done reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!halt, "R2 no halt without request", halt, 0);
    run(1, 0, 0, 0);
    run(1, 1, 3, 0);
    run(2, 2, 5, 0);
    run(0, 0, 1, 0);   // R6 zero count
    run(5, 1, 2, 1);   // R9
    run(3, 2, 7, 0);
    run(15, 0, 4, 1);  // R7 latched select
    run(7, 3, 6, 0);
    for (int g = 0; g < 8; g++) run(2, g % 3, g, 0);
    run(0, 2, 2, 0);
    repeat (4) @(negedge clk);
    check(jobs.size() == 0, "R9 no extra DMA", jobs.size(), 0);
    check(!halt, "R9 idle after busy request", halt, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule